// File: doc/BRIEF.md
# Serial Stereo PCM Output Formatter

This block sends stereo PCM to an external digital-to-analogue converter. An audio decoder hands it left and right samples through a valid/ready handshake. The block puts both channels on one serial data line and marks them with a word-select line and a bit clock. It also produces the oversampling master clock that the converter needs. A 4-bit configuration word picks the sample width, the framing style and the master-clock ratio.

A frame is 64 bit clocks: two slots of 32 bit clocks, one per channel. The frame is always the same length, whatever width is chosen, and unused bit positions carry zero. The block takes a new sample pair only at a frame boundary. The configuration word is also read only at a frame boundary. If the decoder has nothing ready, if the decoder flags an error, or if the controller asks for mute, the next frame carries silence and the clocks keep running. The serial data pad and the master-clock pad each have an output enable that the controller can turn off.

The block runs from a system clock `clk` at twice the master-clock rate. The master clock is `clk`/2. The configuration picks the bit-clock divider, and that choice sets the sample rate: fs is `clk`/512 in 256 fs mode and `clk`/768 in 384 fs mode.

Top module: `pcm_serial_tx`

## Requirements
- R1: `mclk_o` toggles on every `clk` cycle. `bclk_o` has a period of 8 `clk` cycles when `cfg_i[3]`=0 (256 fs) and 12 `clk` cycles when `cfg_i[3]`=1 (384 fs). This holds in muted, underflow and error frames as well.
- R2: A frame is 64 bit clocks: slot bits 0..31 of the first channel, then slot bits 0..31 of the second. `ws_o` and `sd_o` change only when `bclk_o` falls. In I2S framing (`cfg_i[2]`=0), `ws_o` is 0 for the left slot and 1 for the right slot. In right-justified framing (`cfg_i[2]`=1), `ws_o` is 1 for the left slot and 0 for the right slot.
- R3: `cfg_i[1:0]` = 0, 1, 2 or 3 selects a width W of 16, 18, 20 or 22 bits. Samples sit right-aligned on the 22-bit input buses, and input bits at or above W are ignored.
- R4: In I2S framing, slot bit k for k = 1..W carries sample bit W-k, so the MSB comes one bit clock after the word-select change. Every other slot bit is 0.
- R5: In right-justified framing, slot bit k for k = 32-W..31 carries sample bit 31-k, so the LSB is on slot bit 31. Every other slot bit is 0.
- R6: `s_ready` is high for exactly one `clk` cycle per frame, at the frame boundary. A pair is transferred when `s_valid` is also high in that cycle.
- R7: If `s_valid` is low at a boundary, the whole next frame is zero and `underrun_o` is high for that frame.
- R8: If `s_err` or `mute_i` is high at a boundary, the offered pair is consumed and the next frame is all zero. In this case `underrun_o` stays low.
- R9: `cfg_i` is sampled only at a frame boundary. A change made in the middle of a frame leaves the rest of that frame in its old width, framing and bit-clock rate.
- R10: `sd_oe_o` equals the inverse of `hiz_data_i`, and `mclk_oe_o` equals the inverse of `hiz_mclk_i`, each one `clk` cycle later. Clocks and data continue while either enable is low.
- R11: While `rst` is high, `mclk_o`, `bclk_o`, `ws_o`, `sd_o`, `s_ready` and `underrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the master-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Decoder has a sample pair on offer |
| s_ready | output | 1 | Frame boundary; the pair is taken this cycle |
| s_left | input | 22 | Left sample, right-aligned |
| s_right | input | 22 | Right sample, right-aligned |
| s_err | input | 1 | Offered pair is corrupt; silence it |
| mute_i | input | 1 | Controller mute request |
| cfg_i | input | 4 | [3] ratio 384 fs, [2] right-justified, [1:0] width code |
| hiz_data_i | input | 1 | Controller request to release the data pad |
| hiz_mclk_i | input | 1 | Controller request to release the master-clock pad |
| mclk_o | output | 1 | Converter master clock |
| mclk_oe_o | output | 1 | Master-clock pad drive enable |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Channel word select |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Data pad drive enable |
| underrun_o | output | 1 | Current frame lacked a sample pair |

## Verification
The bench decodes every bit of each frame from the pads. It covers all four widths, both framings and both ratios, with junk placed above the chosen width. A design that put the MSB on slot bit 0, or that left-aligned the right-justified data, or that leaked the upper junk bits, would produce wrong frames. A design that dropped the consumed pair or raised `underrun_o` wrongly would be caught in the underflow, error and mute frames, as would one that stalled the bit clock in silent frames. The bench also changes the configuration in the middle of each frame, so a design that switched width or divider early would corrupt that frame's second slot and its bit-clock spacing.

// File: rtl/aso_pkg.sv
package aso_pkg;
  localparam int unsigned WMIN  = 16;
  localparam int unsigned WSTEP = 2;

  typedef enum logic {FMT_I2S = 1'b0, FMT_RJ = 1'b1} fmt_e;

  typedef struct packed {
    logic       ratio_hi;
    fmt_e       fmt;
    logic [1:0] wsel;
  } aso_cfg_t;

  function automatic int width_of(logic [1:0] wsel);
    return int'(WMIN) + int'(WSTEP) * int'(wsel);
  endfunction
endpackage

// File: rtl/aso_clkgen.sv
module aso_clkgen #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_hi,
  output logic mclk,
  output logic bclk,
  output logic fall_evt
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] hc;
  logic [CW-1:0] half_m1;
  logic          wrap;

  assign half_m1  = sel_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign wrap     = (hc == half_m1);
  assign fall_evt = wrap & bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc   <= '0;
      bclk <= 1'b0;
      mclk <= 1'b0;
    end else begin
      mclk <= ~mclk;
      if (wrap) begin
        hc   <= '0;
        bclk <= ~bclk;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aso_framer.sv
module aso_framer #(
  parameter int SLOT = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          step,
  output logic [$clog2(2*SLOT)-1:0]     pos_nxt,
  output logic                          boundary
);
  localparam int PW = $clog2(2*SLOT);

  logic [PW-1:0] pos;

  assign pos_nxt  = pos + 1'b1;
  assign boundary = step & (&pos);

  always_ff @(posedge clk) begin
    if (rst)       pos <= '1;
    else if (step) pos <= pos_nxt;
  end
endmodule

// File: rtl/aso_serializer.sv
module aso_serializer
  import aso_pkg::*;
#(
  parameter int SW   = 22,
  parameter int SLOT = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic                      load,
  input  logic [$clog2(2*SLOT)-1:0] pos_nxt,
  input  aso_cfg_t                  cfg_nxt,
  input  logic [SW-1:0]             in_l,
  input  logic [SW-1:0]             in_r,
  output logic                      sd,
  output logic                      ws
);
  localparam int PW = $clog2(2*SLOT);
  localparam int KW = $clog2(SLOT);
  localparam int IW = $clog2(SW);

  logic [SW-1:0] lat_l, lat_r, word;
  logic [IW-1:0] idx;
  logic          bit_n, ws_n;
  int            k, w;

  always_comb begin
    if (pos_nxt[PW-1]) word = load ? in_r : lat_r;
    else               word = load ? in_l : lat_l;
    k     = int'(pos_nxt[KW-1:0]);
    w     = width_of(cfg_nxt.wsel);
    idx   = '0;
    bit_n = 1'b0;
    if (cfg_nxt.fmt == FMT_I2S) begin
      if (k >= 1 && k <= w) begin
        idx   = IW'(w - k);
        bit_n = word[idx];
      end
    end else begin
      if (k >= SLOT - w) begin
        idx   = IW'(SLOT - 1 - k);
        bit_n = word[idx];
      end
    end
    ws_n = pos_nxt[PW-1] ^ (cfg_nxt.fmt == FMT_RJ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_l <= '0;
      lat_r <= '0;
      sd    <= 1'b0;
      ws    <= 1'b0;
    end else begin
      if (load) begin
        lat_l <= in_l;
        lat_r <= in_r;
      end
      if (step) begin
        sd <= bit_n;
        ws <= ws_n;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import aso_pkg::*;
#(
  parameter int SW     = 22,
  parameter int SLOT   = 32,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_left,
  input  logic [SW-1:0] s_right,
  input  logic          s_err,
  input  logic          mute_i,
  input  logic [3:0]    cfg_i,
  input  logic          hiz_data_i,
  input  logic          hiz_mclk_i,
  output logic          mclk_o,
  output logic          mclk_oe_o,
  output logic          bclk_o,
  output logic          ws_o,
  output logic          sd_o,
  output logic          sd_oe_o,
  output logic          underrun_o
);
  localparam int PW = $clog2(2*SLOT);

  aso_cfg_t      cfg_act, cfg_nxt;
  logic          fall_evt, boundary, silent;
  logic [PW-1:0] pos_nxt;
  logic [SW-1:0] in_l, in_r;

  assign cfg_nxt = boundary ? aso_cfg_t'(cfg_i) : cfg_act;
  assign silent  = mute_i | s_err | ~s_valid;
  assign in_l    = silent ? '0 : s_left;
  assign in_r    = silent ? '0 : s_right;
  assign s_ready = boundary;

  aso_clkgen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_clk (
    .clk(clk), .rst(rst), .sel_hi(cfg_act.ratio_hi),
    .mclk(mclk_o), .bclk(bclk_o), .fall_evt(fall_evt)
  );

  aso_framer #(.SLOT(SLOT)) u_frm (
    .clk(clk), .rst(rst), .step(fall_evt),
    .pos_nxt(pos_nxt), .boundary(boundary)
  );

  aso_serializer #(.SW(SW), .SLOT(SLOT)) u_ser (
    .clk(clk), .rst(rst), .step(fall_evt), .load(boundary),
    .pos_nxt(pos_nxt), .cfg_nxt(cfg_nxt), .in_l(in_l), .in_r(in_r),
    .sd(sd_o), .ws(ws_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_act    <= '0;
      underrun_o <= 1'b0;
      sd_oe_o    <= 1'b0;
      mclk_oe_o  <= 1'b0;
    end else begin
      sd_oe_o   <= ~hiz_data_i;
      mclk_oe_o <= ~hiz_mclk_i;
      if (boundary) begin
        cfg_act    <= cfg_nxt;
        underrun_o <= ~s_valid;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk (
  input logic clk,
  input logic rst,
  input logic s_ready,
  input logic hiz_data_i,
  input logic hiz_mclk_i,
  input logic mclk_o,
  input logic mclk_oe_o,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic sd_oe_o,
  input logic underrun_o
);
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 3) age <= age + 1'b1;
  end
  assign armed = (age == 2'd3);

  // R1
  mclk_toggle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    mclk_o != $past(mclk_o));

  // R2
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (ws_o != $past(ws_o)) |-> ($past(bclk_o) && !bclk_o));

  // R2
  sd_edge_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (sd_o != $past(sd_o)) |-> ($past(bclk_o) && !bclk_o));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    s_ready |=> !s_ready);

  // R7
  underrun_silent_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    underrun_o |-> !sd_o);

  // R10
  sd_oe_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    sd_oe_o == !$past(hiz_data_i));

  // R10
  mclk_oe_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    mclk_oe_o == !$past(hiz_mclk_i));
endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .hiz_data_i(hiz_data_i),
  .hiz_mclk_i(hiz_mclk_i), .mclk_o(mclk_o), .mclk_oe_o(mclk_oe_o),
  .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
  .underrun_o(underrun_o)
);

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
  localparam int NF = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid, s_ready, s_err, mute_i;
  logic [21:0] s_left, s_right;
  logic [3:0]  cfg_i;
  logic        hiz_data_i = 1'b0, hiz_mclk_i = 1'b0;
  logic        mclk_o, mclk_oe_o, bclk_o, ws_o, sd_o, sd_oe_o, underrun_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [21:0] st_l [NF+1];
  logic [21:0] st_r [NF+1];
  logic [3:0]  st_cfg [NF+1];
  logic        st_v [NF+1], st_e [NF+1], st_m [NF+1];

  logic [63:0] cap_sd [NF], cap_ws [NF];
  logic        cap_un [NF];
  int          sp_min [NF], sp_max [NF], rdy_cnt [NF+2];
  int          edge_idx = 0, cyc_since = 0, frames_done = 0;
  logic        prev_bclk = 1'b0;

  always #4 clk = ~clk;

  pcm_serial_tx i_pcm_serial_tx (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .s_err(s_err), .mute_i(mute_i),
    .cfg_i(cfg_i), .hiz_data_i(hiz_data_i), .hiz_mclk_i(hiz_mclk_i),
    .mclk_o(mclk_o), .mclk_oe_o(mclk_oe_o), .bclk_o(bclk_o), .ws_o(ws_o),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o), .underrun_o(underrun_o)
  );

  task automatic apply(int f);
    s_left = st_l[f]; s_right = st_r[f]; cfg_i = st_cfg[f];
    s_valid = st_v[f]; s_err = st_e[f]; mute_i = st_m[f];
  endtask

  task automatic plan(int f, logic [3:0] c, logic [21:0] l, logic [21:0] r,
                      logic v, logic e, logic m);
    st_cfg[f] = c; st_l[f] = l; st_r[f] = r; st_v[f] = v; st_e[f] = e; st_m[f] = m;
  endtask

  // Pad observer: decodes frames at each rising bit clock edge
  always @(negedge clk) begin
    if (rst) begin
      edge_idx = 0; cyc_since = 0; prev_bclk = 1'b0;
    end else begin
      cyc_since++;
      if (s_ready && edge_idx / 64 < NF + 2) rdy_cnt[edge_idx / 64]++;
      if (bclk_o && !prev_bclk) begin
        if (edge_idx >= 1) begin
          int f, p;
          f = (edge_idx - 1) / 64;
          p = (edge_idx - 1) % 64;
          if (f < NF) begin
            cap_sd[f][p] = sd_o;
            cap_ws[f][p] = ws_o;
            if (p >= 2) begin
              if (cyc_since < sp_min[f]) sp_min[f] = cyc_since;
              if (cyc_since > sp_max[f]) sp_max[f] = cyc_since;
            end
            if (p == 5) cap_un[f] = underrun_o;
            if (p == 63) frames_done = f + 1;
          end
          if (p == 16 && f + 1 <= NF) apply(f + 1);
        end
        edge_idx++;
        cyc_since = 0;
      end
      prev_bclk = bclk_o;
    end
  end

  function automatic logic exp_sd(int f, int p);
    int w, k;
    logic [21:0] word;
    if (!st_v[f] || st_e[f] || st_m[f]) return 1'b0;
    w = 16 + 2 * int'(st_cfg[f][1:0]);
    k = p % 32;
    word = (p >= 32) ? st_r[f] : st_l[f];
    if (!st_cfg[f][2]) return (k >= 1 && k <= w) ? word[w - k] : 1'b0;
    return (k >= 32 - w) ? word[31 - k] : 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frame(int f);
    while (frames_done < f + 1) @(negedge clk);
  endtask

  task automatic check_frame(int f, string req);
    logic [63:0] es, ew;
    int sp;
    wait_frame(f);
    for (int p = 0; p < 64; p++) begin
      es[p] = exp_sd(f, p);
      ew[p] = (p >= 32) ^ st_cfg[f][2];
    end
    chk(cap_sd[f] == es, req, $sformatf("frame %0d data bits", f), 0, 0);
    if (cap_sd[f] != es)
      $display("  frame %0d data actual %h expected %h", f, cap_sd[f], es);
    chk(cap_ws[f] == ew, "R2", $sformatf("frame %0d word select", f), 0, 0);
    if (cap_ws[f] != ew)
      $display("  frame %0d ws actual %h expected %h", f, cap_ws[f], ew);
    sp = st_cfg[f][3] ? 12 : 8;
    chk(sp_min[f] == sp && sp_max[f] == sp, "R1",
        $sformatf("frame %0d bit clock period", f), sp_max[f], sp);
    chk(cap_un[f] == !st_v[f], "R7", $sformatf("frame %0d underrun flag", f),
        cap_un[f], !st_v[f]);
    chk(rdy_cnt[f] == 1, "R6", $sformatf("frame %0d ready pulses", f), rdy_cnt[f], 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R11
    chk({mclk_o, bclk_o, ws_o, sd_o, s_ready, underrun_o} == 6'b0, "R11",
        "outputs in reset", {mclk_o, bclk_o, ws_o, sd_o, s_ready, underrun_o}, 0);
  endtask

  task automatic t_i2s();     // R4, R3 widths and ratios
    check_frame(0, "R3");
    check_frame(1, "R4");
    check_frame(2, "R4");
  endtask

  task automatic t_rj();      // R5, R9 mid-frame config change
    check_frame(3, "R5");
    check_frame(4, "R9");
    check_frame(5, "R5");
  endtask

  task automatic t_silence(); // R7 underflow, R8 error and mute
    check_frame(6, "R7");
    check_frame(7, "R8");
    check_frame(8, "R8");
    check_frame(9, "R8");
  endtask

  task automatic t_hiz();     // R10
    int rises = 0;
    logic pb, m0;
    wait_frame(9);
    @(negedge clk);
    chk(sd_oe_o && mclk_oe_o, "R10", "enables before release", {sd_oe_o, mclk_oe_o}, 3);
    hiz_data_i = 1'b1;
    @(negedge clk);
    chk(!sd_oe_o && mclk_oe_o, "R10", "data pad released", {sd_oe_o, mclk_oe_o}, 1);
    hiz_mclk_i = 1'b1;
    @(negedge clk);
    chk(!mclk_oe_o, "R10", "mclk pad released", mclk_oe_o, 0);
    pb = bclk_o;
    m0 = mclk_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_o && !pb) rises++;
      pb = bclk_o;
    end
    chk(rises >= 3, "R10", "bit clock runs while released", rises, 3);
    chk(mclk_o == m0, "R1", "mclk phase after even cycle count", mclk_o, m0);
    hiz_data_i = 1'b0;
    hiz_mclk_i = 1'b0;
    @(negedge clk);
    chk(sd_oe_o && mclk_oe_o, "R10", "enables restored", {sd_oe_o, mclk_oe_o}, 3);
    check_frame(10, "R3");
    check_frame(11, "R4");
  endtask

  initial begin
    for (int f = 0; f < NF; f++) begin
      sp_min[f] = 1000; sp_max[f] = 0; cap_un[f] = 1'bx;
    end
    for (int f = 0; f < NF + 2; f++) rdy_cnt[f] = 0;
    plan(0,  4'b0000, 22'h3FA5C3, 22'h2C1234, 1, 0, 0);
    plan(1,  4'b0001, 22'h3EABCD, 22'h015555, 1, 0, 0);
    plan(2,  4'b1011, 22'h2D3C4B, 22'h123456, 1, 0, 0);
    plan(3,  4'b0100, 22'h2AF00F, 22'h150FF0, 1, 0, 0);
    plan(4,  4'b1110, 22'h3ABCDE, 22'h013579, 1, 0, 0);
    plan(5,  4'b0111, 22'h3A5A5A, 22'h05A5A5, 1, 0, 0);
    plan(6,  4'b0010, 22'h3FFFFF, 22'h3FFFFF, 0, 0, 0);
    plan(7,  4'b0000, 22'h00FFFF, 22'h00FFFF, 1, 1, 0);
    plan(8,  4'b1000, 22'h00FFFF, 22'h00FFFF, 1, 0, 1);
    plan(9,  4'b0000, 22'h008001, 22'h007FFE, 1, 0, 0);
    plan(10, 4'b1101, 22'h03FFFF, 22'h020001, 1, 0, 0);
    plan(11, 4'b0011, 22'h2AAAAB, 22'h155554, 1, 0, 0);
    plan(12, 4'b0000, 22'h001111, 22'h002222, 1, 0, 0);
    apply(0);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_i2s();
    t_rj();
    t_silence();
    t_hiz();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule